// File: doc/BRIEF.md
# Flash Controller Key Unlock Sequencer

This block guards the control register of a flash program/erase controller. After reset the controller is locked: software must write two fixed magic keys, in a set order, to a key register before any write to the control register is taken. A single wrong key while locked freezes the lock until the next reset, which stops runaway code from reaching the erase and program settings by brute force.

A second, independent key sequence, written to an option-key register, sets an option-write-enable flag. Software may clear this flag through the control register but can never set it that way. A wrong option key only restarts that sequence. It never disables the flag for good.

All three registers share one write port with a 2-bit register select. The block outputs the lock state, the permanent-lock state and the option-write-enable flag. It also outputs the operation-select field of the control register together with a one-cycle pulse for every control write it takes. Control writes are also refused while the flash engine reports busy.

Top module: `flash_key_guard`

## Requirements
- R1: After reset `lock_o`=1, `hard_lock_o`=0, `opt_wr_en_o`=0, `ctrl_field_o`=0 and `ctrl_accept_o`=0.
- R2: Writing KEY1 (0x45670123) and then KEY2 (0xCDEF89AB) to the key register (`wr_sel_i`=0) while locked clears `lock_o`. The cleared value is visible in the cycle after the second write.
- R3: While `lock_o`=1, a control-register write (`wr_sel_i`=2) is ignored. `ctrl_field_o`, `lock_o` and `opt_wr_en_o` keep their values and `ctrl_accept_o` stays 0.
- R4: While locked, a key-register write that is not the expected key (a wrong first key or a wrong second key) sets `hard_lock_o`=1 and keeps `lock_o`=1. This state persists until reset, even if the correct key sequence is written afterwards.
- R5: Key-register writes made while unlocked, of any value, leave `lock_o` and `hard_lock_o` unchanged.
- R6: A taken control write with bit 7 set relocks (`lock_o`=1, `hard_lock_o`=0). The normal KEY1, KEY2 sequence then unlocks again.
- R7: `opt_wr_en_o` is set only after KEY1 and then KEY2 are written to the option-key register (`wr_sel_i`=1). A wrong value restarts that sequence, and a later correct pair still sets the flag.
- R8: A taken control write with bit 9 clear clears `opt_wr_en_o`. A control write with bit 9 set never sets it.
- R9: Once set, `opt_wr_en_o` stays set through wrong option-key writes and through further correct option-key sequences.
- R10: While `busy_i`=1, control writes are discarded: no accept pulse, and no change to the field, the lock or the option flag.
- R11: A taken control write loads `ctrl_field_o` from bits [5:0] of `wr_data_i` and raises `ctrl_accept_o` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target register: 0 key, 1 option key, 2 control, 3 none |
| wr_data_i | input | 32 | Write data |
| busy_i | input | 1 | Flash operation in progress |
| lock_o | output | 1 | Control register locked |
| hard_lock_o | output | 1 | Locked until reset |
| opt_wr_en_o | output | 1 | Option-byte operations allowed |
| ctrl_field_o | output | 6 | Operation-select field of the control register |
| ctrl_accept_o | output | 1 | One-cycle pulse after a taken control write |

## Verification
The bench builds the block with its default parameters: a 32-bit write port, the two standard key values, a 6-bit operation field, the relock request at bit 7 and the option-keep bit at bit 9. With these values it can write a value that differs from a key in a single bit, and it can write the second key in the first-key slot. Both cases show that the comparison is exact and depends on the order. Because the relock bit and the option-keep bit lie outside the field, the bench can also set the field to all ones or all zeros while it relocks or clears the option flag in the same write.

// File: rtl/flash_key_pkg.sv
package flash_key_pkg;

  typedef enum logic [1:0] {
    LK_WAIT_K1 = 2'd0,
    LK_WAIT_K2 = 2'd1,
    LK_OPEN    = 2'd2,
    LK_DEAD    = 2'd3
  } lock_st_t;

  typedef enum logic [1:0] {
    SEL_KEY    = 2'd0,
    SEL_OPTKEY = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_t;

  // Next lock state for one key-register write (hit1/hit2: value equals key)
  function automatic lock_st_t lock_step(input lock_st_t cur,
                                         input logic hit1,
                                         input logic hit2);
    lock_st_t nxt;
    nxt = cur;
    unique case (cur)
      LK_WAIT_K1: nxt = hit1 ? LK_WAIT_K2 : LK_DEAD;
      LK_WAIT_K2: nxt = hit2 ? LK_OPEN    : LK_DEAD;
      LK_OPEN:    nxt = LK_OPEN;
      LK_DEAD:    nxt = LK_DEAD;
      default:    nxt = LK_DEAD;
    endcase
    return nxt;
  endfunction

  // Option sequence: 0 = expecting first key, 1 = expecting second key
  function automatic logic opt_step(input logic cur, input logic hit1);
    return cur ? 1'b0 : hit1;
  endfunction

endpackage

// File: rtl/flash_lock_seq.sv
module flash_lock_seq
  import flash_key_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY1 = 32'h4567_0123,
  parameter logic [DATA_W-1:0] KEY2 = 32'hCDEF_89AB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              relock,
  output lock_st_t          state,
  output logic              unlock_evt,
  output logic              dead_evt
);

  lock_st_t st_q, st_d;
  logic     hit1, hit2;

  assign hit1 = (key_data == KEY1);
  assign hit2 = (key_data == KEY2);

  always_comb begin
    st_d = st_q;
    if (key_wr)      st_d = lock_step(st_q, hit1, hit2);
    else if (relock && st_q == LK_OPEN) st_d = LK_WAIT_K1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= LK_WAIT_K1;
    else        st_q <= st_d;
  end

  assign state      = st_q;
  assign unlock_evt = (st_q != LK_OPEN) && (st_d == LK_OPEN);
  assign dead_evt   = (st_q != LK_DEAD) && (st_d == LK_DEAD);

endmodule

// File: rtl/flash_optkey_seq.sv
module flash_optkey_seq
  import flash_key_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY1 = 32'h4567_0123,
  parameter logic [DATA_W-1:0] KEY2 = 32'hCDEF_89AB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              open_evt
);

  logic mid_q;
  logic hit1, hit2;

  assign hit1 = (key_data == KEY1);
  assign hit2 = (key_data == KEY2);

  always_ff @(posedge clk) begin
    if (!rst_n)      mid_q <= 1'b0;
    else if (key_wr) mid_q <= opt_step(mid_q, hit1);
  end

  assign open_evt = key_wr && mid_q && hit2;

endmodule

// File: rtl/flash_ctrl_gate.sv
module flash_ctrl_gate #(
  parameter int FIELD_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic [FIELD_W-1:0] field_in,
  input  logic               relock_bit,
  input  logic               keep_opt_bit,
  input  logic               unlocked,
  input  logic               busy,
  input  logic               opt_open_evt,
  output logic               take,
  output logic               relock,
  output logic [FIELD_W-1:0] field_q,
  output logic               accept_q,
  output logic               opt_en_q
);

  assign take   = ctrl_wr && unlocked && !busy;
  assign relock = take && relock_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q  <= '0;
      accept_q <= 1'b0;
      opt_en_q <= 1'b0;
    end else begin
      accept_q <= take;
      if (take) field_q <= field_in;
      if (opt_open_evt)               opt_en_q <= 1'b1;
      else if (take && !keep_opt_bit) opt_en_q <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_key_guard.sv
module flash_key_guard
  import flash_key_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [DATA_W-1:0] KEY1 = 32'h4567_0123,
  parameter logic [DATA_W-1:0] KEY2 = 32'hCDEF_89AB,
  parameter int          FIELD_W   = 6,
  parameter int          RELOCK_POS = 7,
  parameter int          OPTKEEP_POS = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               busy_i,
  output logic               lock_o,
  output logic               hard_lock_o,
  output logic               opt_wr_en_o,
  output logic [FIELD_W-1:0] ctrl_field_o,
  output logic               ctrl_accept_o
);

  // Named internal events, used by the bound checker
  logic     key_wr, optkey_wr, ctrl_wr;
  logic     ctrl_take, relock, unlock_evt, dead_evt, opt_open_evt;
  lock_st_t lock_st;

  assign key_wr    = wr_en_i && (reg_sel_t'(wr_sel_i) == SEL_KEY);
  assign optkey_wr = wr_en_i && (reg_sel_t'(wr_sel_i) == SEL_OPTKEY);
  assign ctrl_wr   = wr_en_i && (reg_sel_t'(wr_sel_i) == SEL_CTRL);

  flash_lock_seq #(.DATA_W(DATA_W), .KEY1(KEY1), .KEY2(KEY2)) u_lock (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wr_data_i),
    .relock(relock), .state(lock_st), .unlock_evt(unlock_evt),
    .dead_evt(dead_evt)
  );

  flash_optkey_seq #(.DATA_W(DATA_W), .KEY1(KEY1), .KEY2(KEY2)) u_opt (
    .clk(clk), .rst_n(rst_n), .key_wr(optkey_wr), .key_data(wr_data_i),
    .open_evt(opt_open_evt)
  );

  flash_ctrl_gate #(.FIELD_W(FIELD_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .field_in(wr_data_i[FIELD_W-1:0]),
    .relock_bit(wr_data_i[RELOCK_POS]),
    .keep_opt_bit(wr_data_i[OPTKEEP_POS]),
    .unlocked(lock_st == LK_OPEN), .busy(busy_i),
    .opt_open_evt(opt_open_evt), .take(ctrl_take), .relock(relock),
    .field_q(ctrl_field_o), .accept_q(ctrl_accept_o), .opt_en_q(opt_wr_en_o)
  );

  assign lock_o      = (lock_st != LK_OPEN);
  assign hard_lock_o = (lock_st == LK_DEAD);

endmodule

// File: rtl/flash_key_guard_chk.sv
module flash_key_guard_chk #(
  parameter int          DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY1 = 32'h4567_0123,
  parameter logic [DATA_W-1:0] KEY2 = 32'hCDEF_89AB,
  parameter int          FIELD_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic               busy_i,
  input logic               key_wr,
  input logic               optkey_wr,
  input logic               ctrl_wr,
  input logic               lock_o,
  input logic               hard_lock_o,
  input logic               opt_wr_en_o,
  input logic [FIELD_W-1:0] ctrl_field_o,
  input logic               ctrl_accept_o
);

  AST_UNLOCK_NEEDS_KEY2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(key_wr && wr_data_i == KEY2)); // R2

  AST_LOCKED_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && ctrl_wr) |=> (!ctrl_accept_o && $stable(ctrl_field_o))); // R3

  AST_HARD_LOCK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock_o |=> (hard_lock_o && lock_o)); // R4

  AST_OPEN_KEYS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && key_wr) |=> (!lock_o && !hard_lock_o)); // R5

  AST_OPT_SET_BY_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(opt_wr_en_o) |-> $past(optkey_wr && wr_data_i == KEY2)); // R7

  AST_OPT_STAYS_ON_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_wr_en_o && optkey_wr) |=> opt_wr_en_o); // R9

  AST_BUSY_BLOCKS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && ctrl_wr) |=> (!ctrl_accept_o && $stable(ctrl_field_o))); // R10

endmodule

bind flash_key_guard flash_key_guard_chk #(
  .DATA_W(DATA_W), .KEY1(KEY1), .KEY2(KEY2), .FIELD_W(FIELD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data_i(wr_data_i), .busy_i(busy_i),
  .key_wr(key_wr), .optkey_wr(optkey_wr), .ctrl_wr(ctrl_wr),
  .lock_o(lock_o), .hard_lock_o(hard_lock_o), .opt_wr_en_o(opt_wr_en_o),
  .ctrl_field_o(ctrl_field_o), .ctrl_accept_o(ctrl_accept_o)
);

// File: tb/sim_flash_key_guard.sv
`timescale 1ns/1ps
module sim_flash_key_guard;

  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;
  localparam logic [1:0]  S_KEY = 2'd0, S_OPT = 2'd1, S_CTRL = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        lock_o, hard_o, optwe_o, acc_o;
  logic [5:0]  field_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  flash_key_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .busy_i(busy), .lock_o(lock_o),
    .hard_lock_o(hard_o), .opt_wr_en_o(optwe_o),
    .ctrl_field_o(field_o), .ctrl_accept_o(acc_o)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one-cycle write; results visible on return
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic unlock();
    wr(S_KEY, K1);
    wr(S_KEY, K2);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 lock", lock_o, 1);
    check("R1 hard", hard_o, 0);
    check("R1 optwe", optwe_o, 0);
    check("R1 field", field_o, 0);
    check("R1 accept", acc_o, 0);
  endtask

  task automatic t_locked_ctrl();
    do_reset();
    wr(S_CTRL, 32'h0000_003F);
    check("R3 no accept", acc_o, 0);
    check("R3 field", field_o, 0);
    check("R3 lock", lock_o, 1);
  endtask

  task automatic t_unlock();
    do_reset();
    wr(S_KEY, K1);
    check("R2 still locked after key1", lock_o, 1);
    wr(S_KEY, K2);
    check("R2 unlocked", lock_o, 0);
    check("R2 not hard", hard_o, 0);
  endtask

  task automatic t_fields();
    do_reset();
    unlock();
    wr(S_CTRL, 32'h0000_002A);
    check("R11 accept pulse", acc_o, 1);
    check("R11 field", field_o, 6'h2A);
    @(negedge clk);
    check("R11 pulse one cycle", acc_o, 0);
    wr(S_CTRL, 32'h0000_0015);
    check("R11 field2", field_o, 6'h15);
  endtask

  task automatic t_keys_open();
    do_reset();
    unlock();
    wr(S_KEY, 32'h1234_5678);
    check("R5 lock", lock_o, 0);
    check("R5 hard", hard_o, 0);
    wr(S_KEY, K1);
    check("R5 lock after key1", lock_o, 0);
  endtask

  task automatic t_busy();
    do_reset();
    unlock();
    wr(S_CTRL, 32'h0000_0003);
    busy = 1'b1;
    wr(S_CTRL, 32'h0000_00BC);
    check("R10 no accept", acc_o, 0);
    check("R10 field", field_o, 6'h03);
    check("R10 lock", lock_o, 0);
    busy = 1'b0;
    wr(S_CTRL, 32'h0000_003C);
    check("R10 accepted after busy", field_o, 6'h3C);
  endtask

  task automatic t_relock();
    do_reset();
    unlock();
    wr(S_CTRL, 32'h0000_0080);
    check("R6 relocked", lock_o, 1);
    check("R6 not hard", hard_o, 0);
    wr(S_CTRL, 32'h0000_0011);
    check("R6 ctrl ignored after relock", field_o, 0);
    unlock();
    check("R6 unlocked again", lock_o, 0);
  endtask

  task automatic t_hard_first();
    do_reset();
    wr(S_KEY, K2);
    check("R4 hard wrong first", hard_o, 1);
    unlock();
    check("R4 lock stays", lock_o, 1);
    check("R4 hard stays", hard_o, 1);
    wr(S_CTRL, 32'h0000_0001);
    check("R4 ctrl ignored", field_o, 0);
    do_reset();
    unlock();
    check("R4 reset clears hard", lock_o, 0);
  endtask

  task automatic t_hard_second();
    do_reset();
    wr(S_KEY, K1);
    wr(S_KEY, K2 ^ 32'h1);
    check("R4 hard wrong second", hard_o, 1);
    check("R4 lock", lock_o, 1);
  endtask

  task automatic t_optkey();
    do_reset();
    wr(S_OPT, K1);
    wr(S_OPT, 32'h0);
    wr(S_OPT, K2);
    check("R7 broken sequence", optwe_o, 0);
    wr(S_OPT, K2);
    check("R7 key2 alone", optwe_o, 0);
    wr(S_OPT, K1);
    check("R7 after key1", optwe_o, 0);
    wr(S_OPT, K2);
    check("R7 set", optwe_o, 1);
    check("R7 lock untouched", lock_o, 1);
  endtask

  task automatic t_opt_clear();
    do_reset();
    unlock();
    wr(S_CTRL, 32'h0000_0200);
    check("R8 ctrl cannot set", optwe_o, 0);
    wr(S_OPT, K1);
    wr(S_OPT, K2);
    wr(S_CTRL, 32'h0000_0207);
    check("R8 keep bit holds", optwe_o, 1);
    wr(S_CTRL, 32'h0000_0007);
    check("R8 cleared", optwe_o, 0);
    wr(S_OPT, K1);
    wr(S_OPT, K2);
    check("R8 set again", optwe_o, 1);
  endtask

  task automatic t_opt_sticky();
    do_reset();
    wr(S_OPT, K1);
    wr(S_OPT, K2);
    wr(S_OPT, 32'hDEAD_BEEF);
    check("R9 wrong keeps", optwe_o, 1);
    wr(S_OPT, K1);
    wr(S_OPT, K2);
    check("R9 repeat keeps", optwe_o, 1);
    wr(S_CTRL, 32'h0000_0000);
    check("R9 locked ctrl cannot clear", optwe_o, 1);
  endtask

  initial begin
    t_reset();
    t_locked_ctrl();
    t_unlock();
    t_fields();
    t_keys_open();
    t_busy();
    t_relock();
    t_hard_first();
    t_hard_second();
    t_optkey();
    t_opt_clear();
    t_opt_sticky();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule